// File: doc/BRIEF.md
# Parallel Lattice-Reduction Swap Scheduler

This block sequences the iterations of an all-swap lattice reduction on a real upper-triangular basis of `NCOL` columns (4 or 8). It does no arithmetic on the basis. An external processing-element array does the size reduction, the Givens rotations and the column exchanges. The scheduler reads only the squared magnitudes of the diagonal of R, in unsigned fixed point. From these it decides which adjacent column pairs must be exchanged, and it drives the array through its phases with one strobe at a time.

Each iteration has a fixed order. It opens with a size-reduction phase that covers every column. Then a bank of comparators tests one parity class of adjacent pairs at once, using the relaxed neighbour condition: one comparison per pair on two neighbouring diagonal entries. The classes alternate between even and odd. If any pair fails, the block strobes a rotate phase and then a swap phase. The pair mask stays on the output while the array does this work. A run starts only on a new-channel pulse. It ends when two consecutive iterations find nothing to exchange, or when the iteration budget runs out. The convergence status is kept until the next channel arrives.

Top module: `lr_swap_sched`

## Requirements
- R1: While reset is high, and after it falls, the block is idle. All three strobes, `swapMask`, `done`, `timeout` and `reduced` are 0.
- R2: A `newChannel` pulse seen while idle raises `sizeRedStrobe` in the next cycle and clears `reduced`, `timeout` and `swapMask`. A `newChannel` pulse at any other time is ignored, including one in the same cycle as `done`.
- R3: Every iteration opens with a one-cycle `sizeRedStrobe`. No swap decision is made before that phase is acknowledged. The new `swapMask` appears one cycle after the acknowledging edge.
- R4: Bit p of `swapMask` refers to columns p and p+1. The first iteration after a start tests only even p. The next tests only odd p, and the classes keep alternating. A mask never holds bits of both classes.
- R5: Column k's squared diagonal sits at `diagSq[k*DW +: DW]`. Pair p is flagged when 48497·d[p] > 65536·d[p+1]. The constant is (0.99 − 0.25) in 16 fractional bits. Equality is not a violation.
- R6: For a non-zero mask, `rotStrobe` is issued first. `swapStrobe` follows only after the rotate phase is acknowledged. `swapMask` stays unchanged from the rotate strobe through the swap acknowledge.
- R7: A zero mask issues no rotate or swap strobe. The next iteration, of the other parity, begins with its size-reduction strobe.
- R8: Two consecutive iterations with a zero mask end the run. `done` is high for exactly one cycle, and `reduced` rises with it and holds until the next accepted `newChannel`.
- R9: If `MAXITER` iterations complete without convergence, `done` pulses with `timeout` set and `reduced` left at 0. `timeout` holds until the next accepted `newChannel`.
- R10: At most one strobe is high in any cycle, and each lasts one cycle. `phaseAck` has no effect unless the block is waiting on a phase it has strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| newChannel | input | 1 | Start pulse for a new channel matrix |
| diagSq | input | NCOL*DW | Squared diagonal magnitudes of R, column k at bits k*DW upward |
| phaseAck | input | 1 | Datapath acknowledge of the current phase |
| sizeRedStrobe | output | 1 | Starts the all-column size-reduction phase |
| rotStrobe | output | 1 | Starts the rotation phase for the flagged pairs |
| swapStrobe | output | 1 | Starts the column-exchange phase for the flagged pairs |
| swapMask | output | NCOL-1 | Flagged adjacent pairs, bit p = columns p and p+1 |
| done | output | 1 | One-cycle end-of-run pulse |
| timeout | output | 1 | Run ended on the iteration budget |
| reduced | output | 1 | Last run converged |

## Verification
The end-of-run pulse and the start request can fall in the same cycle. The bench provokes this by pulsing `newChannel` in exactly the cycle that `done` is high. It expects the pulse to be lost: no size-reduction strobe follows, and `reduced` and `timeout` keep their values. A later pulse, given while idle, must start a fresh run. The same per-cycle reference model judges this collision, spurious acknowledges while idle, restart pulses in the middle of a run, the boundary at comparator equality, and a frozen basis that runs into the iteration budget.

// File: rtl/lr_sched_pkg.sv
package lr_sched_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SR_GO,
    ST_SR_WAIT,
    ST_TEST,
    ST_EVAL,
    ST_ROT_GO,
    ST_ROT_WAIT,
    ST_SW_GO,
    ST_SW_WAIT,
    ST_FIN
  } phase_e;

  typedef struct packed {
    logic loadMask;
    logic clearMask;
    logic oddSel;
  } pairCtl_t;

endpackage

// File: rtl/lr_pair_cmp.sv
module lr_pair_cmp #(
  parameter int DW      = 24,
  parameter int FRAC    = 16,
  parameter int DELTA_S = 48497
) (
  input  logic [DW-1:0] lowerSq,
  input  logic [DW-1:0] upperSq,
  output logic          violate
);
  localparam int PW = DW + FRAC + 2;

  logic [PW-1:0] scaledLower;
  logic [PW-1:0] scaledUpper;

  always_comb begin
    scaledLower = PW'(lowerSq) * PW'(DELTA_S);
    scaledUpper = PW'(upperSq) << FRAC;
    violate     = scaledLower > scaledUpper;
  end
endmodule

// File: rtl/lr_pair_test.sv
module lr_pair_test
  import lr_sched_pkg::*;
#(
  parameter int NCOL    = 4,
  parameter int DW      = 24,
  parameter int FRAC    = 16,
  parameter int DELTA_S = 48497
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pairCtl_t             ctl,
  input  logic [NCOL*DW-1:0]   diagSq,
  output logic [NCOL-2:0]      pairMask,
  output logic                 maskZero
);
  localparam int NPAIR = NCOL - 1;

  logic [NPAIR-1:0] violation;
  logic [NPAIR-1:0] candidate;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam bit IS_ODD = (p % 2) == 1;
    lr_pair_cmp #(
      .DW(DW),
      .FRAC(FRAC),
      .DELTA_S(DELTA_S)
    ) u_cmp (
      .lowerSq(diagSq[p*DW +: DW]),
      .upperSq(diagSq[(p+1)*DW +: DW]),
      .violate(violation[p])
    );
    assign candidate[p] = violation[p] & (ctl.oddSel == IS_ODD);
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.clearMask) begin
      pairMask <= '0;
    end else if (ctl.loadMask) begin
      pairMask <= candidate;
    end
  end

  assign maskZero = ~|pairMask;

  AST_MASK_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!ctl.loadMask && !ctl.clearMask) |=> $stable(pairMask)) else $error("mask moved"); // R6
endmodule

// File: rtl/lr_phase_ctl.sv
module lr_phase_ctl
  import lr_sched_pkg::*;
#(
  parameter int MAXITER = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     newChannel,
  input  logic     phaseAck,
  input  logic     maskZero,
  output pairCtl_t ctl,
  output logic     sizeRedStrobe,
  output logic     rotStrobe,
  output logic     swapStrobe,
  output logic     done,
  output logic     timeout,
  output logic     reduced
);
  localparam int IW = $clog2(MAXITER + 1);

  phase_e        state;
  logic          oddSel;
  logic          prevZero;
  logic [IW-1:0] iterCnt;
  logic [IW-1:0] iterNext;
  logic          timeoutQ;
  logic          reducedQ;

  assign iterNext = iterCnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      oddSel   <= 1'b0;
      prevZero <= 1'b0;
      iterCnt  <= '0;
      timeoutQ <= 1'b0;
      reducedQ <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (newChannel) begin
            state    <= ST_SR_GO;
            oddSel   <= 1'b0;
            prevZero <= 1'b0;
            iterCnt  <= '0;
            timeoutQ <= 1'b0;
            reducedQ <= 1'b0;
          end
        end
        ST_SR_GO:   state <= ST_SR_WAIT;
        ST_SR_WAIT: if (phaseAck) state <= ST_TEST;
        ST_TEST:    state <= ST_EVAL;
        ST_EVAL: begin
          iterCnt <= iterNext;
          if (maskZero && prevZero) begin
            state    <= ST_FIN;
            reducedQ <= 1'b1;
          end else if (!maskZero) begin
            state <= ST_ROT_GO;
          end else begin
            prevZero <= 1'b1;
            oddSel   <= ~oddSel;
            if (iterNext == IW'(MAXITER)) begin
              state    <= ST_FIN;
              timeoutQ <= 1'b1;
            end else begin
              state <= ST_SR_GO;
            end
          end
        end
        ST_ROT_GO:   state <= ST_ROT_WAIT;
        ST_ROT_WAIT: if (phaseAck) state <= ST_SW_GO;
        ST_SW_GO:    state <= ST_SW_WAIT;
        ST_SW_WAIT: begin
          if (phaseAck) begin
            prevZero <= 1'b0;
            oddSel   <= ~oddSel;
            if (iterCnt == IW'(MAXITER)) begin
              state    <= ST_FIN;
              timeoutQ <= 1'b1;
            end else begin
              state <= ST_SR_GO;
            end
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.loadMask  = (state == ST_TEST);
    ctl.clearMask = (state == ST_IDLE) && newChannel;
    ctl.oddSel    = oddSel;
  end

  assign sizeRedStrobe = (state == ST_SR_GO);
  assign rotStrobe     = (state == ST_ROT_GO);
  assign swapStrobe    = (state == ST_SW_GO);
  assign done          = (state == ST_FIN);
  assign timeout       = timeoutQ;
  assign reduced       = reducedQ;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sizeRedStrobe, rotStrobe, swapStrobe})) else $error("strobes overlap"); // R10
  AST_SR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sizeRedStrobe |=> !sizeRedStrobe) else $error("long size strobe"); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done not a pulse"); // R8
  AST_TIMEOUT_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout) |-> done) else $error("timeout without done"); // R9
  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (rst)
    iterCnt <= IW'(MAXITER)) else $error("iteration overrun"); // R9
  AST_EXCLUSIVE_END: assert property (@(posedge clk) disable iff (rst)
    !(timeout && reduced)) else $error("both end flags"); // R8
endmodule

// File: rtl/lr_swap_sched.sv
module lr_swap_sched
  import lr_sched_pkg::*;
#(
  parameter int NCOL    = 4,
  parameter int DW      = 24,
  parameter int FRAC    = 16,
  parameter int DELTA_Q = 64881,
  parameter int MAXITER = 4 * NCOL
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               newChannel,
  input  logic [NCOL*DW-1:0] diagSq,
  input  logic               phaseAck,
  output logic               sizeRedStrobe,
  output logic               rotStrobe,
  output logic               swapStrobe,
  output logic [NCOL-2:0]    swapMask,
  output logic               done,
  output logic               timeout,
  output logic               reduced
);
  localparam int NPAIR   = NCOL - 1;
  localparam int QUARTER = 1 << (FRAC - 2);
  localparam int DELTA_S = DELTA_Q - QUARTER;

  function automatic logic [NPAIR-1:0] parityBits(input bit odd);
    logic [NPAIR-1:0] b;
    for (int i = 0; i < NPAIR; i++) b[i] = ((i % 2) == 1) == odd;
    return b;
  endfunction

  localparam logic [NPAIR-1:0] EVEN_BITS = parityBits(1'b0);
  localparam logic [NPAIR-1:0] ODD_BITS  = parityBits(1'b1);

  pairCtl_t ctl;
  logic     maskZero;

  lr_phase_ctl #(
    .MAXITER(MAXITER)
  ) u_ctl (
    .clk(clk),
    .rst(rst),
    .newChannel(newChannel),
    .phaseAck(phaseAck),
    .maskZero(maskZero),
    .ctl(ctl),
    .sizeRedStrobe(sizeRedStrobe),
    .rotStrobe(rotStrobe),
    .swapStrobe(swapStrobe),
    .done(done),
    .timeout(timeout),
    .reduced(reduced)
  );

  lr_pair_test #(
    .NCOL(NCOL),
    .DW(DW),
    .FRAC(FRAC),
    .DELTA_S(DELTA_S)
  ) u_test (
    .clk(clk),
    .rst(rst),
    .ctl(ctl),
    .diagSq(diagSq),
    .pairMask(swapMask),
    .maskZero(maskZero)
  );

  AST_MASK_HELD: assert property (@(posedge clk) disable iff (rst)
    (rotStrobe || swapStrobe) |-> $stable(swapMask)) else $error("mask not held"); // R6
  AST_ROT_NONZERO: assert property (@(posedge clk) disable iff (rst)
    rotStrobe |-> (swapMask != '0)) else $error("rotate on empty mask"); // R7
  AST_PARITY_SPLIT: assert property (@(posedge clk) disable iff (rst)
    !((|(swapMask & EVEN_BITS)) && (|(swapMask & ODD_BITS)))) else $error("mixed parity"); // R4
endmodule

// File: tb/sim_lr_swap_sched.sv
module sim_lr_swap_sched;
  localparam int NC  = 4;
  localparam int DW  = 24;
  localparam int CAP = 4 * NC;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          newChannel = 1'b0;
  logic          respAck = 1'b0;
  logic          spurAck = 1'b0;
  logic          ackIn;
  logic [DW-1:0] dv [NC];
  logic [NC*DW-1:0] diagSq;
  logic          sizeRedStrobe, rotStrobe, swapStrobe, done, timeout, reduced;
  logic [NC-2:0] swapMask;

  int  checks = 0;
  int  errors = 0;
  int  cyc = 0;
  bit  frozen = 0;
  bit  anyMask = 0;
  int  ackWait = 0;
  int  latSeq = 0;

  assign ackIn  = respAck | spurAck;
  assign diagSq = {dv[3], dv[2], dv[1], dv[0]};

  always #5 clk = ~clk;

  lr_swap_sched u0 (
    .clk(clk), .rst(rst), .newChannel(newChannel), .diagSq(diagSq),
    .phaseAck(ackIn), .sizeRedStrobe(sizeRedStrobe), .rotStrobe(rotStrobe),
    .swapStrobe(swapStrobe), .swapMask(swapMask), .done(done),
    .timeout(timeout), .reduced(reduced)
  );

  // reference model: 0 idle,1 size strobe,2 size wait,3 test,4 evaluate,
  // 5 rotate strobe,6 rotate wait,7 swap strobe,8 swap wait,9 end
  int        mSt = 0;
  logic [2:0] mMask = '0;
  bit        mOdd = 0, mPrev = 0, mTo = 0, mRed = 0;
  int        mIter = 0;

  function automatic logic [2:0] refMask(input bit odd);
    logic [2:0] m = '0;
    for (int p = 0; p < NC - 1; p++) begin
      longint lo = longint'(dv[p]);
      longint hi = longint'(dv[p+1]);
      if ((((p % 2) == 1) == odd) && (48497 * lo > 65536 * hi)) m[p] = 1'b1;
    end
    return m;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mSt = 0; mMask = '0; mOdd = 0; mPrev = 0; mIter = 0; mTo = 0; mRed = 0;
    end else begin
      case (mSt)
        0: if (newChannel) begin
             mSt = 1; mOdd = 0; mPrev = 0; mIter = 0; mTo = 0; mRed = 0; mMask = '0;
           end
        1: mSt = 2;
        2: if (ackIn) mSt = 3;
        3: begin mMask = refMask(mOdd); mSt = 4; end
        4: begin
             mIter++;
             if (mMask == 0 && mPrev) begin mSt = 9; mRed = 1; end
             else if (mMask != 0) mSt = 5;
             else begin
               mPrev = 1; mOdd = !mOdd;
               if (mIter == CAP) begin mSt = 9; mTo = 1; end else mSt = 1;
             end
           end
        5: mSt = 6;
        6: if (ackIn) mSt = 7;
        7: mSt = 8;
        8: if (ackIn) begin
             mPrev = 0; mOdd = !mOdd;
             if (mIter == CAP) begin mSt = 9; mTo = 1; end else mSt = 1;
           end
        9: mSt = 0;
        default: mSt = 0;
      endcase
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // per-cycle comparison, then datapath stand-in
  always @(negedge clk) begin
    check("R3 sizeRedStrobe", sizeRedStrobe, mSt == 1);
    check("R6 rotStrobe", rotStrobe, mSt == 5);
    check("R6 swapStrobe", swapStrobe, mSt == 7);
    check("R4 R5 swapMask", swapMask, mMask);
    check("R8 done", done, mSt == 9);
    check("R9 timeout", timeout, mTo);
    check("R8 reduced", reduced, mRed);
    if (swapMask != 0) anyMask = 1;
    respAck = 1'b0;
    if (ackWait > 0) begin
      ackWait--;
      if (ackWait == 0) respAck = 1'b1;
    end
    if (!rst && (sizeRedStrobe || rotStrobe || swapStrobe)) begin
      latSeq = (latSeq % 3) + 1;
      ackWait = latSeq;
      if (swapStrobe && !frozen) begin
        for (int p = 0; p < NC - 1; p++) begin
          if (swapMask[p]) begin
            logic [DW-1:0] t;
            t = dv[p]; dv[p] = dv[p+1]; dv[p+1] = t;
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic runCase(input int d0, input int d1, input int d2, input int d3,
                         input bit frz, input int expRed, input int expTo);
    @(negedge clk);
    dv[0] = DW'(d0); dv[1] = DW'(d1); dv[2] = DW'(d2); dv[3] = DW'(d3);
    frozen = frz; anyMask = 0;
    newChannel = 1'b1;
    @(negedge clk);
    newChannel = 1'b0;
    check("R2 start strobe", sizeRedStrobe, 1);
    repeat (4) @(negedge clk);
    newChannel = 1'b1;          // R2 mid-run pulse must be ignored
    @(negedge clk);
    newChannel = 1'b0;
    while (!done) @(negedge clk);
    if (expRed >= 0) check("R8 converged flag", reduced, expRed);
    if (expTo >= 0) check("R9 timeout flag", timeout, expTo);
    newChannel = 1'b1;          // collides with the done cycle
    @(negedge clk);
    newChannel = 1'b0;
    check("R2 pulse at done ignored", sizeRedStrobe, 0);
    spurAck = 1'b1;
    @(negedge clk);
    spurAck = 1'b0;
    check("R10 idle ack ignored", sizeRedStrobe, 0);
    if (expRed >= 0) check("R8 status held", reduced, expRed);
  endtask

  initial begin
    for (int k = 0; k < NC; k++) dv[k] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset strobes", {sizeRedStrobe, rotStrobe, swapStrobe}, 0);
    check("R1 reset flags", {done, timeout, reduced}, 0);
    check("R1 reset mask", swapMask, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", {sizeRedStrobe, done}, 0);

    runCase(10, 20, 30, 40, 0, 1, 0);                  // R7 R8 already reduced
    check("R7 no exchange on sorted basis", anyMask, 0);
    runCase(4000000, 3000000, 2000000, 1000000, 0, 1, 0); // R6 R4
    check("R6 exchanges happened", anyMask, 1);
    runCase(65536, 48497, 100000, 200000, 0, 1, 0);    // R5 equality
    check("R5 equality not flagged", anyMask, 0);
    runCase(65536, 48496, 100000, 200000, 0, 1, 0);    // R5 just over
    check("R5 one below flagged", anyMask, 1);
    runCase(200, 100, 300, 400, 1, 0, 1);              // R9 frozen basis
    for (int n = 0; n < 8; n++) begin
      runCase(int'($urandom_range(1, 16777215)), int'($urandom_range(1, 16777215)),
              int'($urandom_range(1, 16777215)), int'($urandom_range(1, 16777215)),
              n == 7, -1, -1);
    end
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule